// File: doc/BRIEF.md
# Register Exchange Sequencer

This block performs the exchange of the top stack entry with a selected deeper entry of an eight-deep register stack. It runs a fixed schedule on the stack's read and write ports. The top entry and the selected entry are each read into their own holding register. Each holding register stores a sign/exponent field, a fraction and a two-bit class tag. The block then writes the held values back to the opposite positions. Stack accesses never fall in back-to-back cycles. The stack is addressed by position relative to its top, and it returns read data one cycle after a read strobe.

If either operand is tagged empty, the block pulses a request to set the invalid-operation flag. When the invalid-operation flag is unmasked, the instruction ends at once and the stack is not written. When it is masked, each empty operand is first replaced with the default indefinite NaN, and then the exchange completes. The surrounding control pulses `start` with the position in `idx` and waits for `done`.

Top module: `xchg_seq`

## Requirements
- R1: While reset is applied, and in the first cycle after it, `busy`, `done`, `set_invalid`, `stk_rd_en` and `stk_wr_en` are all low.
- R2: When `start` is sampled high while idle, the block does the following. It reads position 0 in the first cycle after that edge. It leaves the second cycle with no access. It reads the position given by `idx` in the third cycle. `idx` is latched at that start edge.
- R3: Two stack accesses (read or write) never occur in consecutive cycles.
- R4: Tag codes are valid 2'b00, zero 2'b01, special 2'b10 and empty 2'b11. If either read operand is tagged empty, `set_invalid` is high for exactly one cycle, the fifth cycle after start. Otherwise it never rises.
- R5: If `inv_masked` is low in the `set_invalid` cycle, `done` follows in the next cycle and nothing is written to the stack.
- R6: With no empty operand, the old value of position `idx` is written to position 0 in the sixth cycle after start. The old top entry is written to position `idx` in the eighth cycle, and `done` rises in the ninth.
- R7: With an empty operand and `inv_masked` high, each empty operand is replaced before write-back. The replacement has the sign/exponent field all ones, fraction bits [63:62] set with all other bits clear, and tag special (2'b10). A non-empty operand keeps its value and tag. The writes fall in cycles eight and ten after start, and `done` rises in cycle eleven.
- R8: `done` lasts one cycle. `busy` is high from the first cycle after start through the `done` cycle.
- R9: `start` has no effect while `busy` is high. The running exchange keeps its latched position, and no second exchange follows.
- R10: With `idx` = 0 and a non-empty top entry, the full sequence runs and the stack content ends unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an exchange (honoured only when idle) |
| idx | input | 3 | Stack position to exchange with the top |
| inv_masked | input | 1 | High when the invalid-operation flag is masked |
| stk_rd_en | output | 1 | Stack read strobe |
| stk_rd_pos | output | 3 | Stack position to read |
| stk_rd_se | input | 16 | Read sign and exponent, valid one cycle after the strobe |
| stk_rd_frac | input | 64 | Read fraction, valid one cycle after the strobe |
| stk_rd_tag | input | 2 | Read class tag, valid one cycle after the strobe |
| stk_wr_en | output | 1 | Stack write strobe |
| stk_wr_pos | output | 3 | Stack position to write |
| stk_wr_se | output | 16 | Write sign and exponent |
| stk_wr_frac | output | 64 | Write fraction |
| stk_wr_tag | output | 2 | Write class tag |
| set_invalid | output | 1 | One-cycle request to set the invalid-operation flag |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle end-of-instruction pulse |

## Verification
The assertions take three things for granted. The stack answers every read strobe with data in exactly the next cycle. The stack does not change the two entries between the read and the write-back. `inv_masked` is settled in the cycle where `set_invalid` is raised. The stimulus meets these conditions. It models the stack as a registered array that only the block writes, and it holds `inv_masked` constant from the start pulse until `done`. `start` is pulsed in the middle of an exchange only to show that it is ignored, and then with a different position so that a wrong latch would be visible.

// File: rtl/xchg_pkg.sv
package xchg_pkg;

  typedef enum logic [1:0] {
    TAG_VALID   = 2'b00,
    TAG_ZERO    = 2'b01,
    TAG_SPECIAL = 2'b10,
    TAG_EMPTY   = 2'b11
  } tag_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_TOP, S_CAP_A, S_RD_SEL, S_CAP_B, S_TEST,
    S_FIX_A, S_FIX_B, S_WR_TOP, S_WR_GAP, S_WR_SEL, S_DONE
  } xstate_e;

  function automatic logic tag_is_empty(input logic [1:0] t);
    return t == TAG_EMPTY;
  endfunction

endpackage

// File: rtl/xchg_tmp.sv
module xchg_tmp
  import xchg_pkg::*;
#(
  parameter int SE_W   = 16,
  parameter int FRAC_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              fix,
  input  logic [SE_W-1:0]   in_se,
  input  logic [FRAC_W-1:0] in_frac,
  input  logic [1:0]        in_tag,
  output logic [SE_W-1:0]   out_se,
  output logic [FRAC_W-1:0] out_frac,
  output logic [1:0]        out_tag,
  output logic              is_empty
);

  // Default indefinite NaN fraction: two leading ones, rest zero.
  function automatic logic [FRAC_W-1:0] nan_frac();
    logic [FRAC_W-1:0] r;
    r = '0;
    r[FRAC_W-1] = 1'b1;
    r[FRAC_W-2] = 1'b1;
    return r;
  endfunction

  logic [SE_W-1:0]   se_q;
  logic [FRAC_W-1:0] frac_q;
  logic [1:0]        tag_q;
  logic              subst_ev;

  assign subst_ev = fix && tag_is_empty(tag_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      se_q   <= '0;
      frac_q <= '0;
      tag_q  <= TAG_EMPTY;
    end else if (load) begin
      se_q   <= in_se;
      frac_q <= in_frac;
      tag_q  <= in_tag;
    end else if (subst_ev) begin
      se_q   <= '1;
      frac_q <= nan_frac();
      tag_q  <= TAG_SPECIAL;
    end
  end

  assign out_se   = se_q;
  assign out_frac = frac_q;
  assign out_tag  = tag_q;
  assign is_empty = tag_is_empty(tag_q);

  // R7: an empty operand becomes the tagged default NaN
  a_r7_nan_subst: assert property (@(posedge clk) disable iff (!rst_n)
    (fix && is_empty) |=> (out_tag == TAG_SPECIAL && (&out_se) && out_frac == nan_frac()));

  // R7: a present operand passes the repair step untouched
  a_r7_keep_present: assert property (@(posedge clk) disable iff (!rst_n)
    (fix && !load && !is_empty) |=> ($stable(out_tag) && $stable(out_se) && $stable(out_frac)));

endmodule

// File: rtl/xchg_ctrl.sv
module xchg_ctrl
  import xchg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic inv_masked,
  input  logic a_empty,
  input  logic b_empty,
  output logic latch_idx,
  output logic rd_en,
  output logic rd_sel,
  output logic load_a,
  output logic load_b,
  output logic fix_a,
  output logic fix_b,
  output logic wr_en,
  output logic wr_sel,
  output logic set_invalid,
  output logic busy,
  output logic done
);

  xstate_e st_q, st_d;
  logic    any_empty;

  assign any_empty = a_empty || b_empty;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:   if (start) st_d = S_RD_TOP;
      S_RD_TOP: st_d = S_CAP_A;
      S_CAP_A:  st_d = S_RD_SEL;
      S_RD_SEL: st_d = S_CAP_B;
      S_CAP_B:  st_d = S_TEST;
      S_TEST: begin
        if (!any_empty)      st_d = S_WR_TOP;
        else if (inv_masked) st_d = S_FIX_A;
        else                 st_d = S_DONE;
      end
      S_FIX_A:  st_d = S_FIX_B;
      S_FIX_B:  st_d = S_WR_TOP;
      S_WR_TOP: st_d = S_WR_GAP;
      S_WR_GAP: st_d = S_WR_SEL;
      S_WR_SEL: st_d = S_DONE;
      S_DONE:   st_d = S_IDLE;
      default:  st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  assign latch_idx   = (st_q == S_IDLE) && start;
  assign rd_en       = (st_q == S_RD_TOP) || (st_q == S_RD_SEL);
  assign rd_sel      = (st_q == S_RD_SEL);
  assign load_a      = (st_q == S_CAP_A);
  assign load_b      = (st_q == S_CAP_B);
  assign fix_a       = (st_q == S_FIX_A);
  assign fix_b       = (st_q == S_FIX_B);
  assign wr_en       = (st_q == S_WR_TOP) || (st_q == S_WR_SEL);
  assign wr_sel      = (st_q == S_WR_SEL);
  assign set_invalid = (st_q == S_TEST) && any_empty;
  assign busy        = (st_q != S_IDLE);
  assign done        = (st_q == S_DONE);

  // R3: one quiet cycle after every stack access
  a_r3_access_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) |=> !(rd_en || wr_en));

  // R4: the invalid request is a single-cycle pulse
  a_r4_inv_single: assert property (@(posedge clk) disable iff (!rst_n)
    set_invalid |=> !set_invalid);

  // R5: unmasked invalid ends the instruction without a write
  a_r5_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (set_invalid && !inv_masked) |=> (done && !wr_en));

  // R8: done is one cycle and returns the block to idle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R2: a start in idle issues the top-of-stack read next
  a_r2_first_read: assert property (@(posedge clk) disable iff (!rst_n)
    latch_idx |=> (rd_en && !rd_sel));

endmodule

// File: rtl/xchg_seq.sv
module xchg_seq
  import xchg_pkg::*;
#(
  parameter int SE_W   = 16,
  parameter int FRAC_W = 64,
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  idx,
  input  logic              inv_masked,
  output logic              stk_rd_en,
  output logic [IDX_W-1:0]  stk_rd_pos,
  input  logic [SE_W-1:0]   stk_rd_se,
  input  logic [FRAC_W-1:0] stk_rd_frac,
  input  logic [1:0]        stk_rd_tag,
  output logic              stk_wr_en,
  output logic [IDX_W-1:0]  stk_wr_pos,
  output logic [SE_W-1:0]   stk_wr_se,
  output logic [FRAC_W-1:0] stk_wr_frac,
  output logic [1:0]        stk_wr_tag,
  output logic              set_invalid,
  output logic              busy,
  output logic              done
);

  localparam int NTMP = 2;   // holding register 0 keeps the top entry, 1 the selected entry

  logic             latch_idx, rd_sel, wr_sel;
  logic             load_a, load_b, fix_a, fix_b;
  logic [IDX_W-1:0] idx_q;

  logic              t_load  [NTMP];
  logic              t_fix   [NTMP];
  logic [SE_W-1:0]   t_se    [NTMP];
  logic [FRAC_W-1:0] t_frac  [NTMP];
  logic [1:0]        t_tag   [NTMP];
  logic              t_empty [NTMP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         idx_q <= '0;
    else if (latch_idx) idx_q <= idx;
  end

  xchg_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .inv_masked  (inv_masked),
    .a_empty     (t_empty[0]),
    .b_empty     (t_empty[1]),
    .latch_idx   (latch_idx),
    .rd_en       (stk_rd_en),
    .rd_sel      (rd_sel),
    .load_a      (load_a),
    .load_b      (load_b),
    .fix_a       (fix_a),
    .fix_b       (fix_b),
    .wr_en       (stk_wr_en),
    .wr_sel      (wr_sel),
    .set_invalid (set_invalid),
    .busy        (busy),
    .done        (done)
  );

  assign t_load[0] = load_a;
  assign t_load[1] = load_b;
  assign t_fix[0]  = fix_a;
  assign t_fix[1]  = fix_b;

  for (genvar g = 0; g < NTMP; g++) begin : g_tmp
    xchg_tmp #(.SE_W(SE_W), .FRAC_W(FRAC_W)) u_tmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load[g]),
      .fix      (t_fix[g]),
      .in_se    (stk_rd_se),
      .in_frac  (stk_rd_frac),
      .in_tag   (stk_rd_tag),
      .out_se   (t_se[g]),
      .out_frac (t_frac[g]),
      .out_tag  (t_tag[g]),
      .is_empty (t_empty[g])
    );
  end

  assign stk_rd_pos  = rd_sel ? idx_q : '0;
  assign stk_wr_pos  = wr_sel ? idx_q : '0;
  // Crossed write-back: selected entry goes to the top, top entry to the selected slot
  assign stk_wr_se   = wr_sel ? t_se[0]   : t_se[1];
  assign stk_wr_frac = wr_sel ? t_frac[0] : t_frac[1];
  assign stk_wr_tag  = wr_sel ? t_tag[0]  : t_tag[1];

  // R9: the latched position holds for the whole exchange
  a_r9_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(idx_q));

  // R6: a write never carries an empty tag after the check step
  a_r6_no_empty_write: assert property (@(posedge clk) disable iff (!rst_n)
    stk_wr_en |-> (stk_wr_tag != TAG_EMPTY));

endmodule

// File: tb/xchg_seq_tb.sv
module xchg_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SE_W = 16;
  localparam int FRAC_W = 64;
  localparam int DEPTH = 8;
  localparam int IDX_W = 3;
  localparam logic [SE_W-1:0]   NAN_SE = 16'hFFFF;
  localparam logic [FRAC_W-1:0] NAN_FR = {2'b11, 62'd0};

  logic clk, rst_n, start, inv_masked;
  logic [IDX_W-1:0] idx;
  logic stk_rd_en, stk_wr_en, set_invalid, busy, done;
  logic [IDX_W-1:0] stk_rd_pos, stk_wr_pos;
  logic [SE_W-1:0] stk_rd_se, stk_wr_se;
  logic [FRAC_W-1:0] stk_rd_frac, stk_wr_frac;
  logic [1:0] stk_rd_tag, stk_wr_tag;

  xchg_seq #(.SE_W(SE_W), .FRAC_W(FRAC_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .idx(idx), .inv_masked(inv_masked),
    .stk_rd_en(stk_rd_en), .stk_rd_pos(stk_rd_pos), .stk_rd_se(stk_rd_se),
    .stk_rd_frac(stk_rd_frac), .stk_rd_tag(stk_rd_tag),
    .stk_wr_en(stk_wr_en), .stk_wr_pos(stk_wr_pos), .stk_wr_se(stk_wr_se),
    .stk_wr_frac(stk_wr_frac), .stk_wr_tag(stk_wr_tag),
    .set_invalid(set_invalid), .busy(busy), .done(done));

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Stack storage seen by the block: registered read, write on the edge
  logic [SE_W-1:0]   mem_se [DEPTH];
  logic [FRAC_W-1:0] mem_fr [DEPTH];
  logic [1:0]        mem_tg [DEPTH];
  logic [SE_W-1:0]   sh_se [DEPTH];
  logic [FRAC_W-1:0] sh_fr [DEPTH];
  logic [1:0]        sh_tg [DEPTH];

  always @(posedge clk) begin
    if (stk_rd_en) begin
      stk_rd_se   <= mem_se[stk_rd_pos];
      stk_rd_frac <= mem_fr[stk_rd_pos];
      stk_rd_tag  <= mem_tg[stk_rd_pos];
    end
    if (stk_wr_en) begin
      mem_se[stk_wr_pos] <= stk_wr_se;
      mem_fr[stk_wr_pos] <= stk_wr_frac;
      mem_tg[stk_wr_pos] <= stk_wr_tag;
    end
  end

  // Reference model: phase counter of the running exchange
  int ph = 0;
  logic m_err = 0, m_msk = 0;
  logic [IDX_W-1:0] m_idx = '0;
  logic [SE_W-1:0] ea_se, eb_se;
  logic [FRAC_W-1:0] ea_fr, eb_fr;
  logic [1:0] ea_tg, eb_tg;

  function automatic int last_phase(input logic err, input logic msk);
    if (err && !msk) return 6;
    if (err) return 11;
    return 9;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) ph <= 0;
    else if (ph == 0) begin
      if (start) begin
        ph    <= 1;
        m_idx <= idx;
        m_msk <= inv_masked;
        m_err <= (mem_tg[0] == 2'b11) || (mem_tg[idx] == 2'b11);
        ea_se <= (mem_tg[0] == 2'b11) ? NAN_SE : mem_se[0];
        ea_fr <= (mem_tg[0] == 2'b11) ? NAN_FR : mem_fr[0];
        ea_tg <= (mem_tg[0] == 2'b11) ? 2'b10  : mem_tg[0];
        eb_se <= (mem_tg[idx] == 2'b11) ? NAN_SE : mem_se[idx];
        eb_fr <= (mem_tg[idx] == 2'b11) ? NAN_FR : mem_fr[idx];
        eb_tg <= (mem_tg[idx] == 2'b11) ? 2'b10  : mem_tg[idx];
      end
    end else if (ph == last_phase(m_err, m_msk)) ph <= 0;
    else ph <= ph + 1;
  end

  task automatic check(input bit ok, input string req, input logic [81:0] act, input logic [81:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    bit abort, e_rd, e_wr, e_inv, e_done, e_busy, wr_top;
    int w, last;
    string wreq;
    if (rst_n && !finished) begin
      abort  = m_err && !m_msk;
      w      = (m_err && m_msk) ? 2 : 0;
      last   = last_phase(m_err, m_msk);
      wreq   = (w != 0) ? "R7" : "R6";
      e_rd   = (ph == 1) || (ph == 3);
      wr_top = !abort && (ph == 6 + w);
      e_wr   = wr_top || (!abort && (ph == 8 + w));
      e_inv  = m_err && (ph == 5);
      e_done = (ph != 0) && (ph == last);
      e_busy = (ph != 0);
      check(stk_rd_en == e_rd, "R2 read strobe", stk_rd_en, e_rd);
      if (e_rd)
        check(stk_rd_pos == ((ph == 3) ? m_idx : 3'd0), "R2 read position", stk_rd_pos, (ph == 3) ? m_idx : 3'd0);
      check(stk_wr_en == e_wr, abort ? "R5 write strobe" : {wreq, " write strobe"}, stk_wr_en, e_wr);
      if (e_wr && stk_wr_en) begin
        if (wr_top)
          check(stk_wr_pos == 3'd0 && {stk_wr_se, stk_wr_frac, stk_wr_tag} == {eb_se, eb_fr, eb_tg},
                {wreq, " write to top"}, {stk_wr_pos, stk_wr_se, stk_wr_frac, stk_wr_tag},
                {3'd0, eb_se, eb_fr, eb_tg});
        else
          check(stk_wr_pos == m_idx && {stk_wr_se, stk_wr_frac, stk_wr_tag} == {ea_se, ea_fr, ea_tg},
                {wreq, " write to selected"}, {stk_wr_pos, stk_wr_se, stk_wr_frac, stk_wr_tag},
                {m_idx, ea_se, ea_fr, ea_tg});
      end
      check(set_invalid == e_inv, "R4 set_invalid", set_invalid, e_inv);
      check(done == e_done, "R8 done", done, e_done);
      check(busy == e_busy, "R8 busy", busy, e_busy);
    end
  end

  task automatic set_entry(input int k, input logic [SE_W-1:0] s, input logic [FRAC_W-1:0] f, input logic [1:0] t);
    mem_se[k] = s; mem_fr[k] = f; mem_tg[k] = t;
  endtask

  task automatic summary();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic run_op(input int i, input bit msk, input bit poke, input string req);
    bit err;
    logic [SE_W-1:0] as, bs;
    logic [FRAC_W-1:0] af, bf;
    logic [1:0] at, bt;
    int n;
    for (int k = 0; k < DEPTH; k++) begin
      sh_se[k] = mem_se[k]; sh_fr[k] = mem_fr[k]; sh_tg[k] = mem_tg[k];
    end
    err = (mem_tg[0] == 2'b11) || (mem_tg[i] == 2'b11);
    as = (mem_tg[0] == 2'b11) ? NAN_SE : mem_se[0];
    af = (mem_tg[0] == 2'b11) ? NAN_FR : mem_fr[0];
    at = (mem_tg[0] == 2'b11) ? 2'b10 : mem_tg[0];
    bs = (mem_tg[i] == 2'b11) ? NAN_SE : mem_se[i];
    bf = (mem_tg[i] == 2'b11) ? NAN_FR : mem_fr[i];
    bt = (mem_tg[i] == 2'b11) ? 2'b10 : mem_tg[i];
    if (!(err && !msk)) begin
      sh_se[0] = bs; sh_fr[0] = bf; sh_tg[0] = bt;
      sh_se[i] = as; sh_fr[i] = af; sh_tg[i] = at;
    end
    inv_masked = msk;
    idx = i[IDX_W-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      @(negedge clk);
      idx = i[IDX_W-1:0] + 3'd1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1, {req, " exchange completes"}, done, 1'b1);
    @(negedge clk);
    for (int k = 0; k < DEPTH; k++)
      check({mem_se[k], mem_fr[k], mem_tg[k]} == {sh_se[k], sh_fr[k], sh_tg[k]},
            {req, " stack content"}, {mem_se[k], mem_fr[k], mem_tg[k]}, {sh_se[k], sh_fr[k], sh_tg[k]});
    if (poke) begin
      repeat (4) @(negedge clk);
      check(busy == 1'b0, "R9 no second exchange", busy, 1'b0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; idx = '0; inv_masked = 1'b1;
    stk_rd_se = '0; stk_rd_frac = '0; stk_rd_tag = '0;
    set_entry(0, 16'h3FFF, 64'h8000_0000_0000_0001, 2'b00);
    set_entry(1, 16'h0000, 64'h0,                   2'b01);
    set_entry(2, 16'h7FFF, 64'h8000_0000_0000_0000, 2'b10);
    set_entry(3, 16'hC005, 64'hA5A5_0000_1234_5678, 2'b00);
    set_entry(4, 16'h1234, 64'hDEAD_BEEF_0000_0000, 2'b11);
    set_entry(5, 16'h4002, 64'hC000_0000_0000_0000, 2'b00);
    set_entry(6, 16'h0000, 64'h0,                   2'b11);
    set_entry(7, 16'h8000, 64'h0,                   2'b01);
    repeat (3) @(negedge clk);
    check({busy, done, set_invalid, stk_rd_en, stk_wr_en} == 5'b0, "R1 in reset",
          {busy, done, set_invalid, stk_rd_en, stk_wr_en}, 5'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done, set_invalid, stk_rd_en, stk_wr_en} == 5'b0, "R1 after reset",
          {busy, done, set_invalid, stk_rd_en, stk_wr_en}, 5'b0);
    run_op(3, 1'b1, 1'b0, "R6");
    run_op(7, 1'b0, 1'b0, "R6");
    run_op(0, 1'b1, 1'b0, "R10");
    run_op(4, 1'b1, 1'b0, "R7");
    run_op(6, 1'b0, 1'b0, "R5");
    set_entry(0, 16'h5555, 64'h1, 2'b11);
    run_op(2, 1'b1, 1'b0, "R7");
    set_entry(0, 16'h2222, 64'h2, 2'b11);
    set_entry(5, 16'h3333, 64'h3, 2'b11);
    run_op(5, 1'b1, 1'b0, "R7");
    run_op(1, 1'b1, 1'b1, "R9");
    set_entry(0, 16'h0101, 64'h4, 2'b11);
    run_op(0, 1'b0, 1'b0, "R5");
    run_op(0, 1'b1, 1'b0, "R7");
    repeat (3) @(negedge clk);
    summary();
  end

endmodule